// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a sampled host write bus and the program/erase engine of a NOR-style flash array. It watches every write cycle and recognises the unlock-protected command sequences: a four-write word program, six-write sector, block and chip erases, single-write erase suspend and erase resume, a three-write identification entry, and an identification exit. When it recognises a sequence and that sequence is allowed, the block emits a one-cycle start pulse. The pulse carries the operation kind, the address of the final write and its full data word.

The engine reports that it is working through a `busy` input. The decoder keeps a record of which job is running (program, chip erase, or sector/block erase), whether an erase is suspended and which region it was suspended in, and whether identification mode is active. It uses this record to apply the ignore rules. A write-protect input guards the lowest 8 KWord of the array.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While `rst_n` is low, and after it rises, `op_valid`, `id_mode` and `erase_suspended` are 0. Any partly entered sequence is discarded. A job that was running when reset came is forgotten, so commands are decoded again even if `busy` is still high.
- R2: The writes 555h/AAh, 2AAh/55h, 555h/A0h followed by any address and data word give one `op_valid` pulse, one cycle after the last write. It carries `op_kind`=0 (program) together with that write's full address and 16-bit data.
- R3: The writes 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h followed by a final write give an erase pulse. The final write selects the kind: 10h at 555h gives `op_kind`=3 (chip), 50h at any address gives 1 (sector), and 30h at any address gives 2 (block). `op_addr` is the final write's address.
- R4: During unlock and command cycles only address bits 10:0 and data bits 7:0 are compared. Higher bits do not stop a match.
- R5: A write that does not fit the expected next step returns the decoder to read mode. If that write is itself 555h/AAh, it counts as the first step of a new sequence.
- R6: 555h/AAh, 2AAh/55h, 555h/90h sets `id_mode` and pulses `op_kind`=6. A write with data F0h at any step except the program data step clears `id_mode` and pulses `op_kind`=7. This covers both the single F0h write and the three-write form that ends in F0h.
- R7: After a program or chip erase has started, every write is ignored until `busy` has been seen high and then sampled low. A write in the very cycle `busy` is first sampled low is still ignored.
- R8: While a sector or block erase runs, only a write with data B0h is accepted, at any address. It pulses `op_kind`=4 and sets `erase_suspended`. F0h and every other sequence are ignored.
- R9: While suspended, a write with data 30h at any address pulses `op_kind`=5 and clears `erase_suspended`. The erase job is then running again, so other commands are ignored until it completes.
- R10: While suspended, a program outside the suspended 2 KWord sector, or outside the suspended 32 KWord block, is accepted. A program inside that region is rejected, and every erase command is rejected.
- R11: With `wp_n` low, a program or sector erase below word address 2000h is rejected, a block erase of block 0 is rejected, and a chip erase is rejected. With `wp_n` high, these same commands are accepted.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released through a two-flop synchroniser |
| wr_valid | input | 1 | One-cycle strobe marking a sampled host write |
| wr_addr | input | AW (21) | Word address of the write |
| wr_data | input | DW (16) | Data of the write |
| wp_n | input | 1 | Low protects the bottom 8 KWord |
| busy | input | 1 | Engine is executing a program or erase |
| op_valid | output | 1 | One-cycle start pulse |
| op_kind | output | 3 | 0 program, 1 sector erase, 2 block erase, 3 chip erase, 4 suspend, 5 resume, 6 ID entry, 7 ID exit |
| op_addr | output | AW (21) | Address of the accepted final write |
| op_data | output | DW (16) | Data of the accepted final write |
| id_mode | output | 1 | Identification mode active |
| erase_suspended | output | 1 | A sector or block erase is suspended |

## Verification
Two events can land in the same clock edge: the engine finishing a job (`busy` sampled low) and a new command write. The bench provokes this by lowering `busy` in the same cycle it presents the first unlock write of a full program sequence. That write must be ignored, so the rest of the sequence falls apart and no pulse appears. The same sequence one cycle later must be accepted. The suspend path is also checked back to back: a program inside the suspended region and one just outside it are each judged by whether a pulse appears.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [2:0] {
    OP_PROG     = 3'd0,
    OP_SECT     = 3'd1,
    OP_BLK      = 3'd2,
    OP_CHIP     = 3'd3,
    OP_SUSP     = 3'd4,
    OP_RESUME   = 3'd5,
    OP_ID_ENTER = 3'd6,
    OP_ID_EXIT  = 3'd7
  } op_kind_e;

  typedef enum logic [1:0] {
    JOB_NONE  = 2'd0,
    JOB_PROG  = 2'd1,
    JOB_CHIP  = 2'd2,
    JOB_ERASE = 2'd3
  } job_e;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_U1   = 3'd1,
    SQ_U2   = 3'd2,
    SQ_PROG = 3'd3,
    SQ_E3   = 3'd4,
    SQ_E4   = 3'd5,
    SQ_E5   = 3'd6
  } seq_e;

  localparam int CMD_AW = 11;
  localparam int CMD_DW = 8;

  localparam logic [CMD_AW-1:0] KEY_ADDR_A = 11'h555;
  localparam logic [CMD_AW-1:0] KEY_ADDR_B = 11'h2AA;

  localparam logic [CMD_DW-1:0] KEY_FIRST  = 8'hAA;
  localparam logic [CMD_DW-1:0] KEY_SECOND = 8'h55;
  localparam logic [CMD_DW-1:0] CODE_PROG  = 8'hA0;
  localparam logic [CMD_DW-1:0] CODE_ERASE = 8'h80;
  localparam logic [CMD_DW-1:0] CODE_ID    = 8'h90;
  localparam logic [CMD_DW-1:0] CODE_EXIT  = 8'hF0;
  localparam logic [CMD_DW-1:0] CODE_SUSP  = 8'hB0;
  localparam logic [CMD_DW-1:0] CODE_RES   = 8'h30;
  localparam logic [CMD_DW-1:0] CODE_CHIP  = 8'h10;
  localparam logic [CMD_DW-1:0] CODE_SECT  = 8'h50;
  localparam logic [CMD_DW-1:0] CODE_BLK   = 8'h30;
endpackage

// File: rtl/fcd_sequencer.sv
module fcd_sequencer
  import fcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [CMD_AW-1:0] cmd_addr,
  input  logic [CMD_DW-1:0] cmd_data,
  input  job_e              job,
  input  logic              suspended,
  output logic              hit,
  output op_kind_e          hit_kind
);
  seq_e seq_q, seq_d;
  logic is_first;
  logic is_second;
  seq_e restart;

  always_comb begin
    is_first  = (cmd_addr == KEY_ADDR_A) && (cmd_data == KEY_FIRST);
    is_second = (cmd_addr == KEY_ADDR_B) && (cmd_data == KEY_SECOND);
    restart   = is_first ? SQ_U1 : SQ_IDLE;
    seq_d     = seq_q;
    hit       = 1'b0;
    hit_kind  = OP_PROG;
    if (wr_valid) begin
      case (job)
        JOB_PROG, JOB_CHIP: seq_d = SQ_IDLE;
        JOB_ERASE: begin
          seq_d = SQ_IDLE;
          if (cmd_data == CODE_SUSP) begin
            hit      = 1'b1;
            hit_kind = OP_SUSP;
          end
        end
        default: begin
          if (seq_q != SQ_PROG && cmd_data == CODE_EXIT) begin
            hit      = 1'b1;
            hit_kind = OP_ID_EXIT;
            seq_d    = SQ_IDLE;
          end else if (seq_q != SQ_PROG && suspended && cmd_data == CODE_RES) begin
            hit      = 1'b1;
            hit_kind = OP_RESUME;
            seq_d    = SQ_IDLE;
          end else begin
            case (seq_q)
              SQ_IDLE: seq_d = restart;
              SQ_U1:   seq_d = is_second ? SQ_U2 : restart;
              SQ_U2: begin
                if (cmd_addr == KEY_ADDR_A && cmd_data == CODE_PROG) begin
                  seq_d = SQ_PROG;
                end else if (cmd_addr == KEY_ADDR_A && cmd_data == CODE_ERASE) begin
                  seq_d = SQ_E3;
                end else if (cmd_addr == KEY_ADDR_A && cmd_data == CODE_ID) begin
                  hit      = 1'b1;
                  hit_kind = OP_ID_ENTER;
                  seq_d    = SQ_IDLE;
                end else begin
                  seq_d = restart;
                end
              end
              SQ_PROG: begin
                hit      = 1'b1;
                hit_kind = OP_PROG;
                seq_d    = SQ_IDLE;
              end
              SQ_E3: seq_d = is_first ? SQ_E4 : SQ_IDLE;
              SQ_E4: seq_d = is_second ? SQ_E5 : restart;
              SQ_E5: begin
                seq_d = SQ_IDLE;
                if (cmd_data == CODE_CHIP && cmd_addr == KEY_ADDR_A) begin
                  hit      = 1'b1;
                  hit_kind = OP_CHIP;
                end else if (cmd_data == CODE_SECT) begin
                  hit      = 1'b1;
                  hit_kind = OP_SECT;
                end else if (cmd_data == CODE_BLK) begin
                  hit      = 1'b1;
                  hit_kind = OP_BLK;
                end else begin
                  seq_d = restart;
                end
              end
              default: seq_d = SQ_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seq_q <= SQ_IDLE;
    else        seq_q <= seq_d;
  end
endmodule

// File: rtl/fcd_guard.sv
module fcd_guard
  import fcd_pkg::*;
#(
  parameter int RW        = 10,
  parameter int PROT_OFS  = 2,
  parameter int BLK_OFS   = 4
) (
  input  op_kind_e        kind,
  input  logic [RW-1:0]   region,
  input  logic            wp_n,
  input  logic            suspended,
  input  logic            susp_blk,
  input  logic [RW-1:0]   susp_region,
  output logic            allow
);
  logic bottom_hit;
  logic blk0_hit;
  logic same_sect;
  logic same_blk;
  logic in_susp;

  always_comb begin
    bottom_hit = (region[RW-1:PROT_OFS] == '0);
    blk0_hit   = (region[RW-1:BLK_OFS] == '0);
    same_sect  = (region == susp_region);
    same_blk   = (region[RW-1:BLK_OFS] == susp_region[RW-1:BLK_OFS]);
    in_susp    = susp_blk ? same_blk : same_sect;
    case (kind)
      OP_PROG: allow = !(!wp_n && bottom_hit) && !(suspended && in_susp);
      OP_SECT: allow = !suspended && !(!wp_n && bottom_hit);
      OP_BLK:  allow = !suspended && !(!wp_n && blk0_hit);
      OP_CHIP: allow = !suspended && wp_n;
      default: allow = 1'b1;
    endcase
  end
endmodule

// File: rtl/fcd_job_tracker.sv
module fcd_job_tracker
  import fcd_pkg::*;
#(
  parameter int RW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          start,
  input  op_kind_e      kind,
  input  logic [RW-1:0] region,
  output job_e          job,
  output logic          suspended,
  output logic          susp_blk,
  output logic [RW-1:0] susp_region,
  output logic          id_mode
);
  job_e          job_q, job_d;
  logic          seen_q, seen_d;
  logic          susp_q, susp_d;
  logic          blk_q, blk_d;
  logic [RW-1:0] reg_q, reg_d;
  logic          id_q, id_d;

  always_comb begin
    job_d  = job_q;
    seen_d = seen_q;
    susp_d = susp_q;
    blk_d  = blk_q;
    reg_d  = reg_q;
    id_d   = id_q;
    if (start) begin
      case (kind)
        OP_PROG: begin job_d = JOB_PROG; seen_d = 1'b0; end
        OP_CHIP: begin job_d = JOB_CHIP; seen_d = 1'b0; end
        OP_SECT, OP_BLK: begin
          job_d  = JOB_ERASE;
          seen_d = 1'b0;
          blk_d  = (kind == OP_BLK);
          reg_d  = region;
        end
        OP_SUSP:     begin job_d = JOB_NONE; seen_d = 1'b0; susp_d = 1'b1; end
        OP_RESUME:   begin job_d = JOB_ERASE; seen_d = 1'b0; susp_d = 1'b0; end
        OP_ID_ENTER: id_d = 1'b1;
        default:     id_d = 1'b0;
      endcase
    end else begin
      if (job_q != JOB_NONE && busy) seen_d = 1'b1;
      if (seen_q && !busy) begin
        job_d  = JOB_NONE;
        seen_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      job_q  <= JOB_NONE;
      seen_q <= 1'b0;
      susp_q <= 1'b0;
      blk_q  <= 1'b0;
      reg_q  <= '0;
      id_q   <= 1'b0;
    end else begin
      job_q  <= job_d;
      seen_q <= seen_d;
      susp_q <= susp_d;
      blk_q  <= blk_d;
      reg_q  <= reg_d;
      id_q   <= id_d;
    end
  end

  assign job         = job_q;
  assign suspended   = susp_q;
  assign susp_blk    = blk_q;
  assign susp_region = reg_q;
  assign id_mode     = id_q;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int AW         = 21,
  parameter int DW         = 16,
  parameter int SECT_BITS  = 11,
  parameter int BLK_BITS   = 15,
  parameter int PROT_SECTS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          wp_n,
  input  logic          busy,
  output logic          op_valid,
  output logic [2:0]    op_kind,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output logic          id_mode,
  output logic          erase_suspended
);
  localparam int PROT_BITS = SECT_BITS + $clog2(PROT_SECTS);
  localparam int RW        = AW - SECT_BITS;
  localparam int PROT_OFS  = PROT_BITS - SECT_BITS;
  localparam int BLK_OFS   = BLK_BITS - SECT_BITS;

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          hit;
  op_kind_e      hit_kind;
  logic          allow;
  logic          accept;
  job_e          job;
  logic          suspended;
  logic          susp_blk;
  logic [RW-1:0] susp_region;
  logic [RW-1:0] region;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];
  assign region    = wr_addr[AW-1:SECT_BITS];

  fcd_sequencer u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_valid  (wr_valid),
    .cmd_addr  (wr_addr[CMD_AW-1:0]),
    .cmd_data  (wr_data[CMD_DW-1:0]),
    .job       (job),
    .suspended (suspended),
    .hit       (hit),
    .hit_kind  (hit_kind)
  );

  fcd_guard #(.RW(RW), .PROT_OFS(PROT_OFS), .BLK_OFS(BLK_OFS)) u_guard (
    .kind        (hit_kind),
    .region      (region),
    .wp_n        (wp_n),
    .suspended   (suspended),
    .susp_blk    (susp_blk),
    .susp_region (susp_region),
    .allow       (allow)
  );

  assign accept = hit && allow;

  fcd_job_tracker #(.RW(RW)) u_jobs (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .busy        (busy),
    .start       (accept),
    .kind        (hit_kind),
    .region      (region),
    .job         (job),
    .suspended   (suspended),
    .susp_blk    (susp_blk),
    .susp_region (susp_region),
    .id_mode     (id_mode)
  );

  op_kind_e      kind_q;
  logic          valid_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q <= 1'b0;
      kind_q  <= OP_PROG;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= accept;
      if (accept) begin
        kind_q <= hit_kind;
        addr_q <= wr_addr;
        data_q <= wr_data;
      end
    end
  end

  assign op_valid        = valid_q;
  assign op_kind         = kind_q;
  assign op_addr         = addr_q;
  assign op_data         = data_q;
  assign erase_suspended = suspended;
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
  import fcd_pkg::*;
#(
  parameter int HI_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wp_n,
  input logic            op_valid,
  input logic [2:0]      op_kind,
  input logic [HI_W-1:0] op_addr_hi,
  input logic            id_mode,
  input logic            erase_suspended
);
  assert_prog_then_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == OP_PROG) |=> !op_valid);

  assert_susp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_suspended) |-> (op_valid && op_kind == OP_SUSP));

  assert_resume_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == OP_RESUME) |-> !erase_suspended);

  assert_id_enter_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> (op_valid && op_kind == OP_ID_ENTER));

  assert_wp_bottom_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_kind == OP_PROG || op_kind == OP_SECT) && !$past(wp_n))
      |-> (op_addr_hi != '0));

  assert_wp_chip_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == OP_CHIP) |-> $past(wp_n));

  assert_no_erase_in_susp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_kind == OP_SECT || op_kind == OP_BLK || op_kind == OP_CHIP))
      |-> !$past(erase_suspended));
endmodule

bind flash_cmd_decoder fcd_checker #(.HI_W(AW - PROT_BITS)) u_fcd_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .wp_n            (wp_n),
  .op_valid        (op_valid),
  .op_kind         (op_kind),
  .op_addr_hi      (op_addr[AW-1:PROT_BITS]),
  .id_mode         (id_mode),
  .erase_suspended (erase_suspended)
);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  localparam int AW = 21;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_valid;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          wp_n;
  logic          busy;
  logic          op_valid;
  logic [2:0]    op_kind;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  logic          id_mode;
  logic          erase_suspended;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  logic [2:0]    last_kind;
  logic [AW-1:0] last_addr;
  logic [DW-1:0] last_data;

  always #5 clk = ~clk;

  flash_cmd_decoder uut (
    .clk (clk), .rst_n (rst_n), .wr_valid (wr_valid), .wr_addr (wr_addr),
    .wr_data (wr_data), .wp_n (wp_n), .busy (busy), .op_valid (op_valid),
    .op_kind (op_kind), .op_addr (op_addr), .op_data (op_data),
    .id_mode (id_mode), .erase_suspended (erase_suspended)
  );

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    report();
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sample();
    if (op_valid) begin
      pulses++;
      last_kind = op_kind;
      last_addr = op_addr;
      last_data = op_data;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); sample(); end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    sample();
  endtask

  task automatic prog_seq(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr(21'h555, 16'h00AA); wr(21'h2AA, 16'h0055); wr(21'h555, 16'h00A0); wr(a, d);
  endtask

  task automatic erase_seq(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr(21'h555, 16'h00AA); wr(21'h2AA, 16'h0055); wr(21'h555, 16'h0080);
    wr(21'h555, 16'h00AA); wr(21'h2AA, 16'h0055); wr(a, d);
  endtask

  task automatic id_enter_seq();
    wr(21'h555, 16'h00AA); wr(21'h2AA, 16'h0055); wr(21'h555, 16'h0090);
  endtask

  task automatic run_busy();
    busy = 1'b1; idle(3); busy = 1'b0; idle(2);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(3);
  endtask

  task automatic t_reset_state();
    chk("R1 op_valid after reset", op_valid, 0);
    chk("R1 id_mode after reset", id_mode, 0);
    chk("R1 erase_suspended after reset", erase_suspended, 0);
  endtask

  task automatic t_program();
    pulses = 0;
    prog_seq(21'h12345, 16'hBEEF);
    chk("R2 program pulse count", pulses, 1);
    chk("R2 program kind", last_kind, 0);
    chk("R2 program addr", last_addr, 21'h12345);
    chk("R2 program data", last_data, 16'hBEEF);
    idle(1);
    chk("R2 pulse is one cycle", pulses, 1);
    busy = 1'b1; idle(3);
    pulses = 0;
    prog_seq(21'h00400, 16'h1111);
    wr(21'h0, 16'h00F0);
    chk("R7 writes ignored while program busy", pulses, 0);
    busy = 1'b0;
    prog_seq(21'h00400, 16'h2222);
    chk("R7 write in cycle busy drops is ignored", pulses, 0);
    prog_seq(21'h00400, 16'h3333);
    chk("R7 accepted after busy done", pulses, 1);
    run_busy();
  endtask

  task automatic t_erases();
    pulses = 0;
    erase_seq(21'h0A800, 16'h0050);
    chk("R3 sector erase count", pulses, 1);
    chk("R3 sector erase kind", last_kind, 1);
    chk("R3 sector erase addr", last_addr, 21'h0A800);
    run_busy();
    pulses = 0;
    erase_seq(21'h40000, 16'h0030);
    chk("R3 block erase kind", last_kind, 2);
    chk("R3 block erase addr", last_addr, 21'h40000);
    run_busy();
    pulses = 0;
    erase_seq(21'h00555, 16'h0010);
    chk("R3 chip erase count", pulses, 1);
    chk("R3 chip erase kind", last_kind, 3);
    busy = 1'b1; idle(3);
    pulses = 0;
    erase_seq(21'h0A800, 16'h0050);
    wr(21'h0, 16'h00B0);
    chk("R7 writes ignored while chip erase busy", pulses, 0);
    busy = 1'b0; idle(2);
  endtask

  task automatic t_wide_bits();
    pulses = 0;
    wr(21'h1FF555, 16'h12AA); wr(21'h0AA2AA, 16'hFF55); wr(21'h100555, 16'h77A0);
    wr(21'h0ABCD, 16'h5A5A);
    chk("R4 upper bits ignored count", pulses, 1);
    chk("R4 full data reported", last_data, 16'h5A5A);
    run_busy();
  endtask

  task automatic t_breaks();
    pulses = 0;
    wr(21'h555, 16'h00AA); wr(21'h2AA, 16'h0055); wr(21'h555, 16'h0077);
    wr(21'h555, 16'h00A0); wr(21'h03000, 16'h4444);
    chk("R5 broken sequence gives no pulse", pulses, 0);
    wr(21'h555, 16'h00AA); wr(21'h2AA, 16'h0055); wr(21'h555, 16'h00AA);
    wr(21'h2AA, 16'h0055); wr(21'h555, 16'h00A0); wr(21'h03000, 16'h5555);
    chk("R5 first unlock restarts sequence", pulses, 1);
    chk("R5 restarted program data", last_data, 16'h5555);
    run_busy();
  endtask

  task automatic t_id();
    pulses = 0;
    id_enter_seq();
    chk("R6 id entry kind", last_kind, 6);
    chk("R6 id_mode set", id_mode, 1);
    wr(21'h1234, 16'h00F0);
    chk("R6 single exit kind", last_kind, 7);
    chk("R6 id_mode cleared", id_mode, 0);
    id_enter_seq();
    pulses = 0;
    wr(21'h555, 16'h00AA); wr(21'h2AA, 16'h0055); wr(21'h555, 16'h00F0);
    chk("R6 three-write exit count", pulses, 1);
    chk("R6 three-write exit clears", id_mode, 0);
  endtask

  task automatic t_suspend();
    pulses = 0;
    erase_seq(21'h20800, 16'h0050);
    busy = 1'b1; idle(3);
    pulses = 0;
    prog_seq(21'h30000, 16'h6666);
    wr(21'h0, 16'h00F0);
    wr(21'h0, 16'h0030);
    chk("R8 only suspend accepted during erase", pulses, 0);
    wr(21'h1234, 16'h00B0);
    chk("R8 suspend pulse", pulses, 1);
    chk("R8 suspend kind", last_kind, 4);
    chk("R8 suspended flag", erase_suspended, 1);
    busy = 1'b0; idle(2);
    pulses = 0;
    prog_seq(21'h20900, 16'h7777);
    chk("R10 program in suspended sector rejected", pulses, 0);
    prog_seq(21'h21000, 16'h8888);
    chk("R10 program outside suspended sector", pulses, 1);
    run_busy();
    pulses = 0;
    erase_seq(21'h30000, 16'h0050);
    chk("R10 erase rejected while suspended", pulses, 0);
    wr(21'h7777, 16'h0030);
    chk("R9 resume kind", last_kind, 5);
    chk("R9 suspended cleared", erase_suspended, 0);
    pulses = 0;
    wr(21'h0, 16'h00F0);
    chk("R9 erase running again after resume", pulses, 0);
    run_busy();
    erase_seq(21'h48000, 16'h0030);
    busy = 1'b1; idle(3);
    wr(21'h0, 16'h00B0);
    busy = 1'b0; idle(2);
    pulses = 0;
    prog_seq(21'h4F000, 16'h9999);
    chk("R10 program in suspended block rejected", pulses, 0);
    prog_seq(21'h50000, 16'hAAAA);
    chk("R10 program outside suspended block", pulses, 1);
    run_busy();
    wr(21'h0, 16'h0030);
    run_busy();
    chk("R9 suspend cleared after block resume", erase_suspended, 0);
  endtask

  task automatic t_protect();
    wp_n = 1'b0;
    pulses = 0;
    prog_seq(21'h01FFF, 16'h1234);
    erase_seq(21'h01800, 16'h0050);
    erase_seq(21'h07000, 16'h0030);
    erase_seq(21'h00555, 16'h0010);
    chk("R11 protected commands rejected", pulses, 0);
    prog_seq(21'h02000, 16'h4321);
    chk("R11 program above protected area", pulses, 1);
    run_busy();
    wp_n = 1'b1;
    pulses = 0;
    prog_seq(21'h00010, 16'h0F0F);
    chk("R11 bottom program with wp_n high", pulses, 1);
    run_busy();
  endtask

  task automatic t_reset_abort();
    pulses = 0;
    wr(21'h555, 16'h00AA); wr(21'h2AA, 16'h0055); wr(21'h555, 16'h00A0);
    do_reset();
    wr(21'h03000, 16'h1357);
    chk("R1 partial sequence discarded by reset", pulses, 0);
    erase_seq(21'h00555, 16'h0010);
    busy = 1'b1; idle(3);
    do_reset();
    pulses = 0;
    id_enter_seq();
    chk("R1 reset forgets running job", pulses, 1);
    wr(21'h0, 16'h00F0);
    busy = 1'b0; idle(2);
    t_reset_state();
  endtask

  initial begin
    rst_n = 1'b1; wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
    wp_n = 1'b1; busy = 1'b0;
    #1 rst_n = 1'b0;
    idle(2);
    chk("R1 op_valid during reset", op_valid, 0);
    rst_n = 1'b1; idle(3);
    t_reset_state();
    t_program();
    t_erases();
    t_wide_bits();
    t_breaks();
    t_id();
    t_suspend();
    t_protect();
    t_reset_abort();
    report();
  end
endmodule